// File: doc/BRIEF.md
# Strobed Parallel Word Receiver with Paced Drain

This block takes words from a software-driven host over a set of parallel pins, one new-data strobe and one ready line back to the host. Every pin entering from the host is asynchronous to the block clock, so the strobe and data are brought through a multi-flop synchronizer before any decision is made on them. A rising strobe starts a capture: the block waits one more synchronized cycle so the bus has settled, stores the word in an on-chip FIFO and raises ready. Ready stays high until the host lowers its strobe. Only then does the exchange end, so each word takes four phases.

The FIFO covers the periods of several milliseconds in which a multitasking host stops sending. When it is full, the block keeps ready low, and the host waits instead of losing data. The read side does not respond to a consumer. A programmable divider opens one read slot every N clock cycles, so words leave as an evenly spaced stream. A slot that finds the FIFO empty sets a sticky underflow flag. The fill level and the full and empty state are visible at all times. The default build carries 8-bit words (ten host pins). Setting `DATA_W` to 16 gives the 18-pin build.

Top module: `hs_rx_fifo`

## Requirements
- R1: While `rst_n` is low at a clock edge, and after it is released, `host_ready`, `out_valid`, `fifo_full` and `underflow` are 0, `fill_level` is 0 and `fifo_empty` is 1.
- R2: After a rising edge of `host_strobe`, the word on `host_data` is stored and `host_ready` goes to 1 within 8 clock cycles, provided the FIFO is not full. The word later appears unchanged on `out_data`.
- R3: `host_ready` stays 1 as long as `host_strobe` stays 1, and no second word is stored during that time. It returns to 0 after the strobe is lowered. A new capture needs a fresh rising strobe.
- R4: If the FIFO holds `DEPTH` words, a new strobe is not acknowledged and `host_ready` stays 0. Once a read slot frees a place, the pending word is stored and acknowledged, and no word is ever dropped.
- R5: `fill_level` equals the number of stored words (0 to `DEPTH`). `fifo_full` is 1 exactly when it equals `DEPTH`, and `fifo_empty` is 1 exactly when it is 0.
- R6: For `pace_div` = N ≥ 1, a read slot opens every N clock cycles. Each slot that finds the FIFO non-empty gives a one-cycle `out_valid` pulse, and words come out in arrival order. With the FIFO non-empty, consecutive pulses are exactly N cycles apart.
- R7: A read slot that finds the FIFO empty sets `underflow` to 1, and it stays 1 until `flag_clr` is sampled high at a clock edge with no such slot in the same cycle. If both happen in one cycle, the flag is set.
- R8: `pace_div` = 0 stops the drain. No read slot opens, `fill_level` does not fall, `out_valid` stays 0 and `underflow` is not set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_data | input | DATA_W | Asynchronous word pins from the host |
| host_strobe | input | 1 | Asynchronous new-data strobe from the host |
| host_ready | output | 1 | Acknowledge to the host (high = word taken) |
| pace_div | input | DIV_W | Read slot period in cycles (0 = drain stopped) |
| flag_clr | input | 1 | Clears the sticky underflow flag |
| out_data | output | DATA_W | Drained word, valid while `out_valid` is 1 |
| out_valid | output | 1 | One-cycle pulse per drained word |
| fill_level | output | $clog2(DEPTH+1) | Number of words stored |
| fifo_full | output | 1 | FIFO holds DEPTH words |
| fifo_empty | output | 1 | FIFO holds no word |
| underflow | output | 1 | Sticky: a read slot found the FIFO empty |

## Verification
The assertions assume that the host follows the handshake. It places the word before raising the strobe, keeps the word and the strobe steady until it sees ready, and raises the strobe again only after ready has fallen. They also assume that `pace_div` changes only between drain phases. The bench host task sets the data one cycle ahead of the strobe, waits for ready at each phase with a bounded timeout, and holds data through the stalled full-FIFO case. The bench changes the divider only while the FIFO is empty or the drain is stopped, with one exception: the stall test restarts the drain while the FIFO is full, and no spacing check runs there.

// File: rtl/hsrx_pkg.sv
// Shared types for the strobed parallel receiver.
package hsrx_pkg;
    // Capture handshake states: wait for strobe, let bus settle/store, hold ack.
    typedef enum logic [1:0] {
        CAP_IDLE   = 2'd0,
        CAP_SETTLE = 2'd1,
        CAP_ACK    = 2'd2
    } cap_state_t;
endpackage

// File: rtl/hsrx_sync.sv
// Multi-stage synchronizer for a bundle of asynchronous inputs.
// Assumes the data bits are held stable by the sender around the strobe,
// so skew between bits resolves before they are used.
module hsrx_sync #(
    parameter int W      = 9,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    // Shift the inputs through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/hsrx_capture.sv
// Four-phase capture control: detects a rising synchronized strobe, waits
// one cycle so the data has settled, stores the word when the FIFO has room
// and raises ready until the strobe falls.
// Assumes the host keeps data and strobe steady until it sees ready.
module hsrx_capture
    import hsrx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stb_s,
    input  logic [DATA_W-1:0] data_s,
    input  logic              fifo_full,
    output logic              push,
    output logic [DATA_W-1:0] push_data,
    output logic              ready
);
    cap_state_t state, state_nx;
    logic       stb_d;

    // State and strobe-history registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= CAP_IDLE;
            stb_d <= 1'b0;
        end else begin
            state <= state_nx;
            stb_d <= stb_s;
        end
    end

    // Next-state and store decision.
    always_comb begin
        state_nx = state;
        push     = 1'b0;
        case (state)
            CAP_IDLE:   if (stb_s && !stb_d) state_nx = CAP_SETTLE;
            CAP_SETTLE: if (!fifo_full) begin
                            push     = 1'b1;
                            state_nx = CAP_ACK;
                        end
            CAP_ACK:    if (!stb_s) state_nx = CAP_IDLE;
            default:    state_nx = CAP_IDLE;
        endcase
    end

    assign push_data = data_s;
    assign ready     = (state == CAP_ACK);

    // Never store into a full FIFO.
    assert_no_push_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !fifo_full);
    // Ready persists while the strobe is held.
    assert_ready_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && stb_s) |=> ready);
    // A stored word is followed by the acknowledge.
    assert_push_then_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> ready);
endmodule

// File: rtl/hsrx_fifo.sv
// Word FIFO with registered read output and an occupancy counter.
// Assumes the writer never pushes while full; reads on empty are ignored.
module hsrx_fifo #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 16,
    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_req,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic [CW-1:0]     count,
    output logic              full,
    output logic              empty
);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wptr, rptr;
    logic              do_wr, do_rd;

    assign full  = (count == CW'(DEPTH));
    assign empty = (count == '0);
    assign do_wr = wr_en && !full;
    assign do_rd = rd_req && !empty;

    // Storage array write.
    always_ff @(posedge clk) begin
        if (do_wr) mem[wptr] <= wr_data;
    end

    // Pointers, occupancy and registered read port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr     <= '0;
            rptr     <= '0;
            count    <= '0;
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            if (do_wr) wptr <= (wptr == LAST) ? '0 : wptr + 1'b1;
            if (do_rd) begin
                rptr    <= (rptr == LAST) ? '0 : rptr + 1'b1;
                rd_data <= mem[rptr];
            end
            rd_valid <= do_rd;
            case ({do_wr, do_rd})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // Occupancy never exceeds the depth.
    assert_level_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));
    // Occupancy moves by at most one word per cycle.
    assert_level_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (count == $past(count)) || (count == $past(count) + 1'b1)
        || (count == $past(count) - 1'b1));
    // Every output pulse comes from a read slot.
    assert_valid_from_slot_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(rd_req));
endmodule

// File: rtl/hsrx_pacer.sv
// Fixed-rate read slot generator and sticky underflow flag.
// A divisor of N gives a slot every N cycles; 0 stops the slots.
module hsrx_pacer #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div,
    input  logic             fifo_empty,
    input  logic             clr,
    output logic             rd_req,
    output logic             underflow
);
    logic [DIV_W-1:0] cnt;
    logic             slot;

    // Slot decision from the cycle counter.
    always_comb begin
        slot = 1'b0;
        if (div != '0) slot = (cnt >= div - DIV_W'(1));
    end

    // Cycle counter, restarted at each slot or while stopped.
    always_ff @(posedge clk) begin
        if (!rst_n)                    cnt <= '0;
        else if (div == '0 || slot)    cnt <= '0;
        else                           cnt <= cnt + 1'b1;
    end

    // Sticky underflow: a setting event wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)                   underflow <= 1'b0;
        else if (slot && fifo_empty)  underflow <= 1'b1;
        else if (clr)                 underflow <= 1'b0;
    end

    assign rd_req = slot && !fifo_empty;

    // Flag stays set until cleared.
    assert_underflow_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (underflow && !clr) |=> underflow);
    // Reads only happen while data is present.
    assert_read_nonempty_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> !fifo_empty);
endmodule

// File: rtl/hs_rx_fifo.sv
// Top level: synchronizes host pins, runs the four-phase capture, buffers
// words in a FIFO and drains them at a programmed fixed rate.
// Assumes host_data and host_strobe are asynchronous and follow the handshake.
module hs_rx_fifo #(
    parameter int DATA_W      = 8,
    parameter int DEPTH       = 16,
    parameter int DIV_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [DATA_W-1:0]            host_data,
    input  logic                         host_strobe,
    output logic                         host_ready,
    input  logic [DIV_W-1:0]             pace_div,
    input  logic                         flag_clr,
    output logic [DATA_W-1:0]            out_data,
    output logic                         out_valid,
    output logic [$clog2(DEPTH+1)-1:0]   fill_level,
    output logic                         fifo_full,
    output logic                         fifo_empty,
    output logic                         underflow
);
    logic [DATA_W:0]   sync_q;
    logic              push, rd_req;
    logic [DATA_W-1:0] push_data;

    hsrx_sync #(.W(DATA_W + 1), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({host_strobe, host_data}),
        .q     (sync_q)
    );

    hsrx_capture #(.DATA_W(DATA_W)) u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .stb_s     (sync_q[DATA_W]),
        .data_s    (sync_q[DATA_W-1:0]),
        .fifo_full (fifo_full),
        .push      (push),
        .push_data (push_data),
        .ready     (host_ready)
    );

    hsrx_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (push),
        .wr_data  (push_data),
        .rd_req   (rd_req),
        .rd_data  (out_data),
        .rd_valid (out_valid),
        .count    (fill_level),
        .full     (fifo_full),
        .empty    (fifo_empty)
    );

    hsrx_pacer #(.DIV_W(DIV_W)) u_pace (
        .clk        (clk),
        .rst_n      (rst_n),
        .div        (pace_div),
        .fifo_empty (fifo_empty),
        .clr        (flag_clr),
        .rd_req     (rd_req),
        .underflow  (underflow)
    );

    // Ready only falls once the synchronized strobe is low.
    assert_ready_falls_after_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(host_ready) && !host_ready) |-> !$past(sync_q[DATA_W]));
    // A stopped drain never lowers the fill level.
    assert_halt_keeps_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(pace_div) == '0 && !$past(out_valid)) |-> !out_valid);
endmodule

// File: tb/tb_hs_rx_fifo.sv
module tb_hs_rx_fifo;
    localparam int DW = 8;
    localparam int DP = 16;
    localparam int VW = 8;
    localparam int LW = $clog2(DP + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [DW-1:0] host_data = '0;
    logic          host_strobe = 1'b0;
    logic          host_ready;
    logic [VW-1:0] pace_div = '0;
    logic          flag_clr = 1'b0;
    logic [DW-1:0] out_data;
    logic          out_valid;
    logic [LW-1:0] fill_level;
    logic          fifo_full, fifo_empty, underflow;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int gap_chk = 0;
    int last_v  = -1;
    logic [DW-1:0] exp_q[$];

    always #4 clk = ~clk;   // 125 MHz
    always @(posedge clk) cyc <= cyc + 1;

    hs_rx_fifo #(.DATA_W(DW), .DEPTH(DP), .DIV_W(VW)) dut (
        .clk(clk), .rst_n(rst_n), .host_data(host_data), .host_strobe(host_strobe),
        .host_ready(host_ready), .pace_div(pace_div), .flag_clr(flag_clr),
        .out_data(out_data), .out_valid(out_valid), .fill_level(fill_level),
        .fifo_full(fifo_full), .fifo_empty(fifo_empty), .underflow(underflow)
    );

    task automatic check(input string req, input int act, input int expv);
        checks++;
        if (act != expv) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, expv, cyc);
        end
    endtask

    // Output monitor: order of words (R2, R6) and pulse spacing (R6).
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (exp_q.size() == 0) begin
                check("R6 unexpected word", 1, 0);
            end else begin
                check("R2/R6 word order", int'(out_data), int'(exp_q.pop_front()));
            end
            if (gap_chk != 0 && last_v >= 0) check("R6 spacing", cyc - last_v, gap_chk);
            last_v = cyc;
        end
    end

    task automatic wait_ready(input logic lvl, input int limit, output bit ok);
        ok = 1'b0;
        for (int i = 0; i < limit; i++) begin
            @(negedge clk);
            if (host_ready == lvl) begin ok = 1'b1; break; end
        end
    endtask

    task automatic send_word(input logic [DW-1:0] w);
        bit ok;
        exp_q.push_back(w);
        @(negedge clk); host_data = w;
        @(negedge clk); host_strobe = 1'b1;
        wait_ready(1'b1, 8, ok);
        check("R2 ready raised", ok, 1);
        host_strobe = 1'b0;
        wait_ready(1'b0, 8, ok);
        check("R3 ready dropped", ok, 1);
    endtask

    task automatic wait_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset;
        @(negedge clk);
        check("R1 ready", host_ready, 0);
        check("R1 valid", out_valid, 0);
        check("R1 level", fill_level, 0);
        check("R1 empty", fifo_empty, 1);
        check("R1 full", fifo_full, 0);
        check("R1 underflow", underflow, 0);
    endtask

    task automatic t_four_phase;
        bit ok;
        exp_q.push_back(8'hA5);
        @(negedge clk); host_data = 8'hA5;
        @(negedge clk); host_strobe = 1'b1;
        wait_ready(1'b1, 8, ok);
        check("R2 ready raised", ok, 1);
        wait_cycles(12);
        check("R3 ready held", host_ready, 1);
        check("R3 single store", fill_level, 1);
        check("R5 not empty", fifo_empty, 0);
        host_strobe = 1'b0;
        wait_ready(1'b0, 8, ok);
        check("R3 ready dropped", ok, 1);
        wait_cycles(4);
        check("R3 no extra store", fill_level, 1);
    endtask

    task automatic t_full_stall;
        bit ok;
        for (int i = 1; i < DP; i++) send_word(DW'(8'h10 + i));
        wait_cycles(3);
        check("R5 level at depth", fill_level, DP);
        check("R5 full", fifo_full, 1);
        exp_q.push_back(8'h77);
        host_data = 8'h77;
        @(negedge clk); host_strobe = 1'b1;
        wait_cycles(30);
        check("R4 ready withheld", host_ready, 0);
        check("R4 level unchanged", fill_level, DP);
        pace_div = 4;
        wait_ready(1'b1, 40, ok);
        check("R4 ack after space", ok, 1);
        host_strobe = 1'b0;
        wait_ready(1'b0, 8, ok);
        check("R4 ready dropped", ok, 1);
        wait_cycles(4 * (DP + 4));
        check("R4 all words delivered", exp_q.size(), 0);
        check("R5 empty after drain", fifo_empty, 1);
    endtask

    task automatic t_spacing;
        pace_div = 0;
        wait_cycles(2);
        for (int i = 0; i < 6; i++) send_word(DW'(8'hC0 + 3 * i));
        wait_cycles(2);
        check("R8 level held", fill_level, 6);
        last_v = -1;
        gap_chk = 5;
        pace_div = 5;
        wait_cycles(40);
        gap_chk = 0;
        check("R6 drained", exp_q.size(), 0);
    endtask

    task automatic t_stream;
        pace_div = 1;
        for (int i = 0; i < 5; i++) send_word(DW'(8'h3C ^ i));
        wait_cycles(6);
        check("R6 stream delivered", exp_q.size(), 0);
    endtask

    task automatic t_underflow;
        check("R7 set on empty slot", underflow, 1);
        pace_div = 0;
        wait_cycles(2);
        flag_clr = 1'b1;
        @(negedge clk); flag_clr = 1'b0;
        @(negedge clk);
        check("R7 cleared", underflow, 0);
        send_word(8'h5E);
        wait_cycles(30);
        check("R8 no underflow while stopped", underflow, 0);
        check("R8 level kept", fill_level, 1);
        pace_div = 3;
        wait_cycles(20);
        check("R8 drained after restart", exp_q.size(), 0);
        check("R7 set again", underflow, 1);
    endtask

    task automatic finish_run;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (5) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_reset();
        t_four_phase();
        t_full_stall();
        t_spacing();
        t_stream();
        t_underflow();
        finish_run();
    end
endmodule